// File: doc/BRIEF.md
# PCM Codec Serial Port

This block moves voice samples between a serial PCM line and a codec core. The PCM side has three inputs: a bit clock, an 8 kHz frame sync and receive data. It has one output, transmit data. The codec side has parallel sample buses. All logic runs on a free-running system clock that is several times faster than the bit clock. The block resynchronises the three serial inputs and finds the bit-clock and sync edges by comparing each synchronised level with its value one cycle earlier.

A frame starts at a rising bit-clock edge that sees the sync level high. Transmit bits leave on rising edges and receive bits are taken on falling edges. The slot is 8 bits for the companded formats (A-law and mu-law share the same framing) and 16 bits for linear samples. A link monitor watches for a stuck sync or a stuck bit clock. When either is stuck, or when the power-down input is high, the port holds its output high, abandons any frame in progress and raises a power-down indication.

The framing logic uses two-state machines: TX_IDLE/TX_SHIFT, RX_IDLE/RX_SHIFT and MON_DOWN/MON_UP.

**Transmit machine**
- TX_IDLE goes to TX_SHIFT on a frame start while the port is active.
- TX_SHIFT restarts on a new frame start.
- TX_SHIFT returns to TX_IDLE on the rising edge after the last slot bit, or when the port becomes inactive.

**Receive machine**
- RX_IDLE goes to RX_SHIFT on a frame start.
- RX_SHIFT returns to RX_IDLE on the falling edge that samples the last bit, or when the port becomes inactive.
- RX_SHIFT restarts on a new frame start.

**Monitor machine**
- MON_DOWN goes to MON_UP on a sync rising edge.
- MON_UP goes to MON_DOWN when either timeout expires.

Each serial input takes effect SYNC_STAGES+1 system clocks after it changes.

Top module: `pcm_port`

## Requirements
- R1: A receive sample is made of the serial input levels present at the falling bit-clock edges of the slot, first bit most significant.
- R2: The serial output changes only after a rising bit-clock edge, or when the port becomes inactive.
- R3: A frame starts at a rising bit-clock edge where the sync input is high. The first slot bit, the sample's most significant bit, is driven at that same edge. The transmit sample and the format are captured there.
- R4: Format codes 2'b00 (A-law), 2'b01 (mu-law) and 2'b11 each give an 8-bit slot. The slot is taken from tx_sample_i[7:0], and the received byte appears on rx_sample_o[7:0] with the upper bits zero.
- R5: Format code 2'b10 (linear) gives a 16-bit slot: tx_sample_i[13:0], most significant bit first, followed by two 1 bits. The first 14 received bits appear on rx_sample_o[13:0].
- R6: The serial output is high whenever no slot bit is being sent.
- R7: While pdn_i is high or the link is down, the serial output is held high, frames are abandoned and pwrdn_o is high.
- R8: When no sync rising edge arrives for SYNC_LOSS_CYCLES system clocks, the link goes down.
- R9: When no bit-clock edge arrives for BCLK_LOSS_CYCLES system clocks, the link goes down.
- R10: After reset the link is down. A sync rising edge brings it up.
- R11: rx_valid_o pulses for exactly one cycle after the final bit of a slot has been sampled. rx_sample_o holds its value until the next such pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_bclk_i | input | 1 | Serial bit clock (asynchronous) |
| pcm_fsync_i | input | 1 | 8 kHz frame sync (asynchronous) |
| pcm_sdin_i | input | 1 | Serial receive data |
| pcm_sdout_o | output | 1 | Serial transmit data, idle high |
| fmt_i | input | 2 | Sample format code |
| pdn_i | input | 1 | Forced power-down |
| tx_sample_i | input | SAMPLE_W | Sample to transmit, captured at frame start |
| rx_sample_o | output | SAMPLE_W | Last received sample |
| rx_valid_o | output | 1 | One-cycle pulse when rx_sample_o is updated |
| pwrdn_o | output | 1 | Power-down indication (link down or pdn_i) |

## Verification
The in-RTL properties are checked on every cycle. They cover:
- the serial output changes only after a rising edge or a deactivation;
- the output is high one cycle after the port becomes inactive;
- the receive strobe is a single cycle and follows a falling edge;
- narrow samples have zero upper bits;
- the link comes up only after a sync edge.

Only the bench scenarios can show the rest: correct bit order and slot length in each format, the exact cycle at which each loss timeout expires, and recovery after a stuck bit clock, a missing sync or a forced power-down. The bench shows these by comparing every output against its own timing model on every clock.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W = 14;
    localparam int SLOT_W   = 16;
    localparam int CNT_W    = $clog2(SLOT_W + 1);

    localparam logic [1:0] FMT_LINEAR = 2'b10;

    typedef enum logic { TX_IDLE, TX_SHIFT } tx_state_e;
    typedef enum logic { RX_IDLE, RX_SHIFT } rx_state_e;
    typedef enum logic { MON_DOWN, MON_UP } mon_state_e;

    function automatic logic is_linear(input logic [1:0] fmt);
        return fmt == FMT_LINEAR;
    endfunction

    function automatic logic [CNT_W-1:0] slot_bits(input logic lin);
        return lin ? CNT_W'(SLOT_W) : CNT_W'(8);
    endfunction

endpackage

// File: rtl/pcm_port_insync.sv
module pcm_port_insync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pcm_port_linkmon.sv
module pcm_port_linkmon
    import pcm_port_pkg::*;
#(
    parameter int SYNC_LOSS_CYCLES = 6144,
    parameter int BCLK_LOSS_CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rise_i,
    input  logic bclk_edge_i,
    output logic link_up_o
);

    localparam int SW = $clog2(SYNC_LOSS_CYCLES + 1);
    localparam int BW = $clog2(BCLK_LOSS_CYCLES + 1);

    mon_state_e     state_q, state_d;
    logic [SW-1:0]  scnt_q;
    logic [BW-1:0]  bcnt_q;
    logic           sync_expired, bclk_expired;

    assign sync_expired = (scnt_q == SW'(SYNC_LOSS_CYCLES - 1)) && !sync_rise_i;
    assign bclk_expired = (bcnt_q == BW'(BCLK_LOSS_CYCLES - 1)) && !bclk_edge_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_DOWN: if (sync_rise_i) state_d = MON_UP;
            MON_UP:   if (sync_expired || bclk_expired) state_d = MON_DOWN;
            default:  state_d = MON_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_DOWN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            bcnt_q <= '0;
        end else if (state_q == MON_DOWN) begin
            scnt_q <= '0;
            bcnt_q <= '0;
        end else begin
            scnt_q <= sync_rise_i ? '0 : scnt_q + SW'(1);
            bcnt_q <= bclk_edge_i ? '0 : bcnt_q + BW'(1);
        end
    end

    assign link_up_o = (state_q == MON_UP);

    // R10
    mon_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> $past(sync_rise_i));

endmodule

// File: rtl/pcm_port_txfr.sv
module pcm_port_txfr
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                bclk_rise_i,
    input  logic                frame_start_i,
    input  logic [1:0]          fmt_i,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    output logic                sdout_o
);

    tx_state_e          state_q, state_d;
    logic [SLOT_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               lin_q;
    logic               sdout_q;
    logic [SLOT_W-1:0]  slot_word;

    assign slot_word = is_linear(fmt_i) ? {tx_sample_i[13:0], 2'b11}
                                        : {tx_sample_i[7:0], 8'hFF};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:
                if (active_i && frame_start_i) state_d = TX_SHIFT;
            TX_SHIFT:
                if (!active_i)                 state_d = TX_IDLE;
                else if (frame_start_i)        state_d = TX_SHIFT;
                else if (bclk_rise_i && cnt_q == slot_bits(lin_q))
                                               state_d = TX_IDLE;
            default:                           state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdout_q <= 1'b1;
            shreg_q <= '1;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
        end else if (!active_i) begin
            sdout_q <= 1'b1;
        end else if (frame_start_i) begin
            sdout_q <= slot_word[SLOT_W-1];
            shreg_q <= {slot_word[SLOT_W-2:0], 1'b1};
            cnt_q   <= CNT_W'(1);
            lin_q   <= is_linear(fmt_i);
        end else if (state_q == TX_SHIFT && bclk_rise_i) begin
            if (cnt_q == slot_bits(lin_q)) begin
                sdout_q <= 1'b1;
            end else begin
                sdout_q <= shreg_q[SLOT_W-1];
                shreg_q <= {shreg_q[SLOT_W-2:0], 1'b1};
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign sdout_o = sdout_q;

    // R2
    tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout_q != $past(sdout_q)) |-> ($past(bclk_rise_i) || !$past(active_i)));

    // R7
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> sdout_q);

endmodule

// File: rtl/pcm_port_rxfr.sv
module pcm_port_rxfr
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active_i,
    input  logic                bclk_fall_i,
    input  logic                frame_start_i,
    input  logic                sdin_i,
    input  logic [1:0]          fmt_i,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                rx_valid_o
);

    rx_state_e            state_q, state_d;
    logic [SLOT_W-2:0]    acc_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 lin_q;
    logic [SAMPLE_W-1:0]  sample_q;
    logic                 valid_q;
    logic                 last_bit;

    assign last_bit = (cnt_q == slot_bits(lin_q) - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:
                if (active_i && frame_start_i) state_d = RX_SHIFT;
            RX_SHIFT:
                if (!active_i)                 state_d = RX_IDLE;
                else if (frame_start_i)        state_d = RX_SHIFT;
                else if (bclk_fall_i && last_bit) state_d = RX_IDLE;
            default:                           state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            lin_q    <= 1'b0;
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (active_i && frame_start_i) begin
                acc_q <= '0;
                cnt_q <= '0;
                lin_q <= is_linear(fmt_i);
            end else if (active_i && state_q == RX_SHIFT && bclk_fall_i) begin
                acc_q <= {acc_q[SLOT_W-3:0], sdin_i};
                cnt_q <= cnt_q + CNT_W'(1);
                if (last_bit) begin
                    valid_q  <= 1'b1;
                    sample_q <= lin_q ? acc_q[SLOT_W-2:1]
                                      : {6'd0, acc_q[6:0], sdin_i};
                end
            end
        end
    end

    assign rx_sample_o = sample_q;
    assign rx_valid_o  = valid_q;

    // R11
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R1
    rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(bclk_fall_i));

    // R4
    rx_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !lin_q) |-> (sample_q[SAMPLE_W-1:8] == '0));

endmodule

// File: rtl/pcm_port.sv
module pcm_port
    import pcm_port_pkg::*;
#(
    parameter int SYNC_STAGES      = 2,
    parameter int SYNC_LOSS_CYCLES = 6144,
    parameter int BCLK_LOSS_CYCLES = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pcm_bclk_i,
    input  logic                pcm_fsync_i,
    input  logic                pcm_sdin_i,
    output logic                pcm_sdout_o,
    input  logic [1:0]          fmt_i,
    input  logic                pdn_i,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                rx_valid_o,
    output logic                pwrdn_o
);

    logic [2:0] line_s;
    logic [1:0] line_prev_q;
    logic       bclk_s, fsync_s, sdin_s;
    logic       bclk_rise, bclk_fall, bclk_edge, sync_rise, frame_start;
    logic       link_up, active;

    pcm_port_insync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pcm_sdin_i, pcm_fsync_i, pcm_bclk_i}),
        .q_o   (line_s)
    );

    assign bclk_s  = line_s[0];
    assign fsync_s = line_s[1];
    assign sdin_s  = line_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev_q <= '0;
        else        line_prev_q <= {fsync_s, bclk_s};
    end

    assign bclk_rise   =  bclk_s & ~line_prev_q[0];
    assign bclk_fall   = ~bclk_s &  line_prev_q[0];
    assign bclk_edge   =  bclk_s ^  line_prev_q[0];
    assign sync_rise   =  fsync_s & ~line_prev_q[1];
    assign frame_start =  bclk_rise & fsync_s;

    pcm_port_linkmon #(
        .SYNC_LOSS_CYCLES (SYNC_LOSS_CYCLES),
        .BCLK_LOSS_CYCLES (BCLK_LOSS_CYCLES)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_rise_i (sync_rise),
        .bclk_edge_i (bclk_edge),
        .link_up_o   (link_up)
    );

    assign active  = link_up & ~pdn_i;
    assign pwrdn_o = ~link_up | pdn_i;

    pcm_port_txfr u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_i      (active),
        .bclk_rise_i   (bclk_rise),
        .frame_start_i (frame_start),
        .fmt_i         (fmt_i),
        .tx_sample_i   (tx_sample_i),
        .sdout_o       (pcm_sdout_o)
    );

    pcm_port_rxfr u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .active_i      (active),
        .bclk_fall_i   (bclk_fall),
        .frame_start_i (frame_start),
        .sdin_i        (sdin_s),
        .fmt_i         (fmt_i),
        .rx_sample_o   (rx_sample_o),
        .rx_valid_o    (rx_valid_o)
    );

endmodule

// File: tb/sim_pcm_port.sv
module sim_pcm_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int BITS_FRAME = 32;
    localparam int SL         = 2 * BITS_FRAME * 2 * HALF;
    localparam int BL         = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, pdn = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [13:0] txs = '0;
    logic        sdout, rxv, pwrdn;
    logic [13:0] rxs;

    int  n_tests = 0, n_fail = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_port #(
        .SYNC_STAGES      (2),
        .SYNC_LOSS_CYCLES (SL),
        .BCLK_LOSS_CYCLES (BL)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .pcm_bclk_i (bclk), .pcm_fsync_i (fsync), .pcm_sdin_i (sdin),
        .pcm_sdout_o (sdout), .fmt_i (fmt), .pdn_i (pdn),
        .tx_sample_i (txs), .rx_sample_o (rxs), .rx_valid_o (rxv),
        .pwrdn_o (pwrdn)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    logic [2:0] hb, hf, hd;
    bit   m_down, m_tb, m_rb, m_rv, m_tl, m_rl;
    int   m_sc, m_bc, m_ti, m_ri;
    logic m_sd;
    logic [15:0] m_tw;
    int   m_ra;
    logic [13:0] m_rs;

    always @(posedge clk) begin
        if (!rst_n) begin
            hb = 0; hf = 0; hd = 0;
            m_down = 1; m_tb = 0; m_rb = 0; m_rv = 0; m_sd = 1; m_rs = 0;
            m_sc = 0; m_bc = 0;
        end else begin
            bit act, brise, bfall, bedge, srise, fstart;
            int len;
            act    = !m_down && !pdn;
            brise  = hb[1] && !hb[2];
            bfall  = !hb[1] && hb[2];
            bedge  = hb[1] != hb[2];
            srise  = hf[1] && !hf[2];
            fstart = brise && hf[1];
            if (m_down) begin
                if (srise) begin m_down = 0; m_sc = 0; m_bc = 0; end
            end else if ((m_sc == SL-1 && !srise) || (m_bc == BL-1 && !bedge)) begin
                m_down = 1;
            end else begin
                m_sc = srise ? 0 : m_sc + 1;
                m_bc = bedge ? 0 : m_bc + 1;
            end
            if (!act) begin
                m_tb = 0; m_sd = 1;
            end else if (fstart) begin
                m_tl = (fmt == 2'b10);
                m_tw = m_tl ? {txs, 2'b11} : {txs[7:0], 8'hFF};
                m_sd = m_tw[15]; m_ti = 1; m_tb = 1;
            end else if (m_tb && brise) begin
                len = m_tl ? 16 : 8;
                if (m_ti == len) begin m_sd = 1; m_tb = 0; end
                else begin m_sd = m_tw[15-m_ti]; m_ti++; end
            end
            m_rv = 0;
            if (!act) m_rb = 0;
            else if (fstart) begin
                m_rb = 1; m_ri = 0; m_ra = 0; m_rl = (fmt == 2'b10);
            end else if (m_rb && bfall) begin
                len = m_rl ? 16 : 8;
                m_ra = m_ra * 2 + int'(hd[1]);
                m_ri++;
                if (m_ri == len) begin
                    m_rv = 1; m_rb = 0;
                    m_rs = m_rl ? 14'((m_ra >> 2) & 16'h3FFF) : 14'(m_ra & 8'hFF);
                end
            end
            hb = {hb[1:0], bclk};
            hf = {hf[1:0], fsync};
            hd = {hd[1:0], sdin};
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(sdout === m_sd, (m_down || pdn) ? "R7" : (m_tb ? "R2" : "R6"),
                  "sdout vs model", sdout, m_sd);
            check(pwrdn === (m_down || pdn), m_down ? "R8" : "R10",
                  "pwrdn vs model", pwrdn, m_down || pdn);
            check(rxv === m_rv, "R11", "rx_valid vs model", rxv, m_rv);
            check(rxs === m_rs, "R1", "rx_sample vs model", rxs, m_rs);
        end
    end

    logic rec [BITS_FRAME];

    task automatic phase(input logic b, input logic f, input logic d, output logic r);
        bclk = b; fsync = f; sdin = d;
        r = 1'b1;
        for (int c = 0; c < HALF; c++) begin
            @(negedge clk);
            if (c == 3) r = sdout;
        end
    endtask

    task automatic run_frame(input logic [1:0] f, input logic [13:0] tw,
                             input logic [13:0] rw, input bit with_sync,
                             input bit expect_data);
        bit lin;
        int len;
        logic [15:0] rword, tword;
        logic dummy;
        lin   = (f == 2'b10);
        len   = lin ? 16 : 8;
        rword = lin ? {rw, 2'b10} : {rw[7:0], 8'h00};
        tword = lin ? {tw, 2'b11} : {tw[7:0], 8'hFF};
        fmt = f; txs = tw;
        for (int b = 0; b < BITS_FRAME; b++) begin
            phase(1'b0, with_sync && b == 0, sdin, dummy);
            phase(1'b1, with_sync && b == 0, (b < len) ? rword[15-b] : 1'b1, rec[b]);
        end
        if (expect_data) begin
            check(rec[0] === tword[15], "R3", "first slot bit", rec[0], tword[15]);
            for (int j = 1; j < len; j++)
                check(rec[j] === tword[15-j], lin ? "R5" : "R4", "slot bit", rec[j], tword[15-j]);
            for (int j = len; j < BITS_FRAME; j++)
                check(rec[j] === 1'b1, "R6", "idle bit", rec[j], 1);
            check(rxs === (lin ? rw : {6'd0, rw[7:0]}), lin ? "R5" : "R4",
                  "received sample", rxs, lin ? rw : {6'd0, rw[7:0]});
        end else begin
            for (int j = 0; j < BITS_FRAME; j++)
                check(rec[j] === 1'b1, "R7", "held-high bit", rec[j], 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(pwrdn === 1'b1, "R10", "pwrdn in reset", pwrdn, 1);
        check(sdout === 1'b1, "R7", "sdout in reset", sdout, 1);
        check(rxv === 1'b0, "R11", "rx_valid in reset", rxv, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(pwrdn === 1'b1, "R10", "down before first sync", pwrdn, 1);

        run_frame(2'b00, 14'h00A5, 14'h005A, 1, 1);
        run_frame(2'b01, 14'h0081, 14'h00C3, 1, 1);
        run_frame(2'b10, 14'h2ABC, 14'h1357, 1, 1);
        run_frame(2'b10, 14'h3FFF, 14'h0001, 1, 1);
        run_frame(2'b11, 14'h3F00, 14'h00FF, 1, 1);
        check(pwrdn === 1'b0, "R10", "link up after frames", pwrdn, 0);

        pdn = 1'b1;
        run_frame(2'b00, 14'h0055, 14'h0033, 1, 0);
        check(pwrdn === 1'b1, "R7", "pwrdn follows pdn_i", pwrdn, 1);
        pdn = 1'b0;
        run_frame(2'b00, 14'h0096, 14'h0069, 1, 1);

        repeat (BL + 8) @(negedge clk);
        check(pwrdn === 1'b1, "R9", "stuck bit clock", pwrdn, 1);
        check(sdout === 1'b1, "R7", "sdout with stuck clock", sdout, 1);
        run_frame(2'b10, 14'h1234, 14'h2DCB, 1, 1);

        run_frame(2'b00, 14'h0011, 14'h0022, 0, 0);
        run_frame(2'b00, 14'h0011, 14'h0022, 0, 0);
        run_frame(2'b00, 14'h0011, 14'h0022, 0, 0);
        check(pwrdn === 1'b1, "R8", "missing sync", pwrdn, 1);
        run_frame(2'b01, 14'h00E7, 14'h0018, 1, 1);
        check(pwrdn === 1'b0, "R10", "recovered after sync", pwrdn, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule